// File: doc/BRIEF.md
# Diagnostic Progressive Scan Sequencer

This block drives a microprogram through a diagnostic step sequence. A single-cycle start strobe delivers a 32-bit address word, an 8-bit immediate field and the address of the issuing instruction. The sequencer decodes the microprogram address, a 3-bit step count and four mode flags from these operands. It then saves both operands to a fixed scratch area in main storage. After that it opens the processor clock enable for exactly as many cycles as the step count holds.

When the count runs out, the scan flag decides the next action. If the flag is set, the sequencer reads the next chaining word from memory and decodes a new address, count and flag set from it. Counting then resumes. The chain has no length limit and ends at the first word that clears the scan flag. If the supervisory flag is clear, the clock enable stays open with no counting until a new start arrives. A separate channel-clock inhibit output follows a diagnostic bit of the interface register.

The memory request port is valid/ready. Once the sequencer raises `mem_req_valid`, the request (`mem_req_write`, `mem_req_addr`, `mem_req_wdata`) stays unchanged until the cycle in which `mem_req_ready` is high, and the transfer happens in that cycle. A write produces no response. A read is answered by exactly one `mem_rsp_valid` pulse in some later cycle. The sequencer always accepts that pulse, so the response path has no ready signal. Bit 0 is the most significant bit in every field position given below.

Top module: `diag_scan_seq`

## Requirements
- R1: After reset, `busy`, `done`, `cpu_clk_en` and `mem_req_valid` are low, and all decoded fields are zero.
- R2: An accepted start first writes the address word to address 0x80, then writes a word at 0x84 that carries the immediate in bits 0-7 (the top byte) with all other bits zero. Both writes come before the first clock-enable cycle.
- R3: On an accepted start, `uaddr` takes address-word bits 20-31 and `io_mode` takes address-word bit 8.
- R4: On an accepted start, `seq_count` takes immediate bits 1-3 (bit 1 most significant). `sup_en_store` takes bit 5, `scan_on` takes bit 6 and `supervisory` takes bit 7.
- R5: With `supervisory` set, a count of N yields exactly N consecutive `cpu_clk_en` cycles, and the count drops by one in each of them.
- R6: When the count is zero and `scan_on` is set, one read is issued. For a chaining word, `uaddr` takes bits 19-30, `seq_count` takes bits 0-2, `sup_en_store` takes bit 4, `scan_on` takes bit 5, `supervisory` takes bit 6 and `io_mode` takes bit 7. Counting then resumes.
- R7: When the count is zero and `scan_on` is clear under supervision, `cpu_clk_en` stays low and `done` pulses for one cycle with `busy` low.
- R8: Chaining reads go to the instruction address plus 4, then plus 8, and so on, with one read per exhausted count. The chain continues for as long as `scan_on` stays set.
- R9: With `supervisory` clear, `cpu_clk_en` stays high, the count is frozen and `done` never pulses. A new start is accepted in this state.
- R10: A start that arrives while a supervised sequence is busy is ignored. Fields, writes and the clock-enable count are unaffected.
- R11: A memory request stays valid and unchanged until `mem_req_ready` is high. The outcome does not depend on how long ready is held off.
- R12: `chan_clk_inhibit` equals `if_diag_bit` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, one cycle |
| start_word | input | 32 | Address word operand |
| start_imm | input | 8 | Immediate operand |
| instr_addr | input | ADDR_W | Byte address of the issuing instruction |
| if_diag_bit | input | 1 | Diagnostic bit of the interface register |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request ready |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Request byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| cpu_clk_en | output | 1 | Processor clock enable |
| chan_clk_inhibit | output | 1 | Common channel clock inhibit |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| uaddr | output | 12 | Microprogram address register |
| seq_count | output | 3 | Step counter |
| io_mode | output | 1 | I/O mode flag |
| sup_en_store | output | 1 | Supervisory enable storage flag |
| scan_on | output | 1 | Progressive scan flag |
| supervisory | output | 1 | Supervisory flag |

## Verification
Single-segment runs with counts of 5 and 0 compare the counted sequence with the zero-count exit. They also show whether the count is off by one. A three-segment chain uses different counts and flag values in each word, so it shows whether every linkage field lands in its bit position and whether each read goes to the next address. The same chain is run again with ready deasserted on most cycles, which exposes any dependence on handshake timing. A free-running start, a start that must be dropped during a supervised run, and toggles of the diagnostic bit cover the remaining control paths.

// File: rtl/diag_scan_pkg.sv
package diag_scan_pkg;
  localparam int UADDR_W = 12;
  localparam int CNT_W   = 3;
  localparam int WORD_W  = 32;
  localparam int IMM_W   = 8;

  typedef struct packed {
    logic [UADDR_W-1:0] uaddr;
    logic [CNT_W-1:0]   cnt;
    logic               sup_en;
    logic               scan;
    logic               sup;
    logic               io_mode;
  } scan_fields_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_WORD,
    ST_WR_IMM,
    ST_RUN,
    ST_LINK_REQ,
    ST_LINK_WAIT
  } seq_state_e;
endpackage

// File: rtl/diag_field_decode.sv
module diag_field_decode
  import diag_scan_pkg::*;
(
  input  logic [WORD_W-1:0] start_word,
  input  logic [IMM_W-1:0]  start_imm,
  input  logic [WORD_W-1:0] link_word,
  output scan_fields_t      start_f,
  output scan_fields_t      link_f
);
  // Bit 0 is the MSB: word bit k sits at vector index 31-k, immediate bit k at 7-k.
  always_comb begin
    start_f.uaddr   = start_word[UADDR_W-1:0];
    start_f.io_mode = start_word[WORD_W-1-8];
    start_f.cnt     = start_imm[IMM_W-2 -: CNT_W];
    start_f.sup_en  = start_imm[IMM_W-1-5];
    start_f.scan    = start_imm[IMM_W-1-6];
    start_f.sup     = start_imm[IMM_W-1-7];

    link_f.uaddr    = link_word[WORD_W-1-19 -: UADDR_W];
    link_f.cnt      = link_word[WORD_W-1 -: CNT_W];
    link_f.sup_en   = link_word[WORD_W-1-4];
    link_f.scan     = link_word[WORD_W-1-5];
    link_f.sup      = link_word[WORD_W-1-6];
    link_f.io_mode  = link_word[WORD_W-1-7];
  end
endmodule

// File: rtl/diag_mem_port.sv
module diag_mem_port
  import diag_scan_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int SCRATCH_ADDR = 'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [WORD_W-1:0] start_word,
  input  logic [IMM_W-1:0]  start_imm,
  input  seq_state_e        state,
  input  logic [ADDR_W-1:0] link_ptr,
  input  logic              ready,
  output logic              valid,
  output logic              write,
  output logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] wdata
);
  localparam logic [ADDR_W-1:0] SCR0 = ADDR_W'(SCRATCH_ADDR);
  localparam logic [ADDR_W-1:0] SCR1 = ADDR_W'(SCRATCH_ADDR + 4);

  logic [WORD_W-1:0] word_q;
  logic [IMM_W-1:0]  imm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      imm_q  <= '0;
    end else if (capture) begin
      word_q <= start_word;
      imm_q  <= start_imm;
    end
  end

  always_comb begin
    valid = 1'b0;
    write = 1'b0;
    addr  = '0;
    wdata = '0;
    unique case (state)
      ST_WR_WORD:  begin valid = 1'b1; write = 1'b1; addr = SCR0; wdata = word_q; end
      ST_WR_IMM:   begin valid = 1'b1; write = 1'b1; addr = SCR1;
                         wdata = {imm_q, {(WORD_W-IMM_W){1'b0}}}; end
      ST_LINK_REQ: begin valid = 1'b1; addr = link_ptr; end
      default: ;
    endcase
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(addr) && $stable(write) && $stable(wdata));

  // R2
  scratch_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && write |-> (addr == SCR0) || (addr == SCR1));
endmodule

// File: rtl/diag_seq_ctrl.sv
module diag_seq_ctrl
  import diag_scan_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int LINK_STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] instr_addr,
  input  scan_fields_t      start_f,
  input  scan_fields_t      link_f,
  input  logic              req_ready,
  input  logic              rsp_valid,
  output logic              start_ok,
  output seq_state_e        state,
  output scan_fields_t      fields,
  output logic [ADDR_W-1:0] link_ptr,
  output logic              done,
  output logic              clk_en
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(LINK_STRIDE);

  logic cnt_zero;
  assign cnt_zero = (fields.cnt == '0);
  assign start_ok = start && ((state == ST_IDLE) || (state == ST_RUN && !fields.sup));
  assign clk_en   = (state == ST_RUN) && (!fields.sup || !cnt_zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      fields   <= '0;
      link_ptr <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start_ok) begin
        fields   <= start_f;
        link_ptr <= instr_addr + STRIDE;
        state    <= ST_WR_WORD;
      end else begin
        unique case (state)
          ST_WR_WORD: if (req_ready) state <= ST_WR_IMM;
          ST_WR_IMM:  if (req_ready) state <= ST_RUN;
          ST_RUN: begin
            if (fields.sup) begin
              if (!cnt_zero)        fields.cnt <= fields.cnt - 1'b1;
              else if (fields.scan) state <= ST_LINK_REQ;
              else begin
                state <= ST_IDLE;
                done  <= 1'b1;
              end
            end
          end
          ST_LINK_REQ: if (req_ready) state <= ST_LINK_WAIT;
          ST_LINK_WAIT: begin
            if (rsp_valid) begin
              fields   <= link_f;
              link_ptr <= link_ptr + STRIDE;
              state    <= ST_RUN;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_RUN && fields.sup && !cnt_zero |=> fields.cnt == $past(fields.cnt) - 1'b1);

  // R6
  link_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_LINK_WAIT && rsp_valid |=> state == ST_RUN && fields == $past(link_f));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> state == ST_IDLE && !clk_en);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && state != ST_IDLE && state != ST_RUN |=> $stable(fields.uaddr));
endmodule

// File: rtl/diag_scan_seq.sv
module diag_scan_seq
  import diag_scan_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int SCRATCH_ADDR = 'h80,
  parameter int LINK_STRIDE  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       start_word,
  input  logic [7:0]        start_imm,
  input  logic [ADDR_W-1:0] instr_addr,
  input  logic              if_diag_bit,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              cpu_clk_en,
  output logic              chan_clk_inhibit,
  output logic              busy,
  output logic              done,
  output logic [11:0]       uaddr,
  output logic [2:0]        seq_count,
  output logic              io_mode,
  output logic              sup_en_store,
  output logic              scan_on,
  output logic              supervisory
);
  scan_fields_t      start_f, link_f, fields;
  seq_state_e        state;
  logic              start_ok;
  logic [ADDR_W-1:0] link_ptr;

  diag_field_decode u_decode (
    .start_word (start_word),
    .start_imm  (start_imm),
    .link_word  (mem_rsp_data),
    .start_f    (start_f),
    .link_f     (link_f)
  );

  diag_seq_ctrl #(.ADDR_W(ADDR_W), .LINK_STRIDE(LINK_STRIDE)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .instr_addr (instr_addr),
    .start_f    (start_f),
    .link_f     (link_f),
    .req_ready  (mem_req_ready),
    .rsp_valid  (mem_rsp_valid),
    .start_ok   (start_ok),
    .state      (state),
    .fields     (fields),
    .link_ptr   (link_ptr),
    .done       (done),
    .clk_en     (cpu_clk_en)
  );

  diag_mem_port #(.ADDR_W(ADDR_W), .SCRATCH_ADDR(SCRATCH_ADDR)) u_mem (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (start_ok),
    .start_word (start_word),
    .start_imm  (start_imm),
    .state      (state),
    .link_ptr   (link_ptr),
    .ready      (mem_req_ready),
    .valid      (mem_req_valid),
    .write      (mem_req_write),
    .addr       (mem_req_addr),
    .wdata      (mem_req_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chan_clk_inhibit <= 1'b0;
    else        chan_clk_inhibit <= if_diag_bit;
  end

  assign busy         = (state != ST_IDLE);
  assign uaddr        = fields.uaddr;
  assign seq_count    = fields.cnt;
  assign io_mode      = fields.io_mode;
  assign sup_en_store = fields.sup_en;
  assign scan_on      = fields.scan;
  assign supervisory  = fields.sup;

  // R12
  inhibit_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chan_clk_inhibit) |-> $past(if_diag_bit));

  // R2
  write_before_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write |-> !cpu_clk_en);
endmodule

// File: tb/test_diag_scan_seq.sv
module test_diag_scan_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, if_diag_bit = 1'b0;
  logic [31:0] start_word = '0;
  logic [7:0]  start_imm = '0;
  logic [AW-1:0] instr_addr = '0;
  logic mem_req_valid, mem_req_write, mem_req_ready = 1'b1;
  logic [AW-1:0] mem_req_addr;
  logic [31:0] mem_req_wdata, mem_rsp_data = '0;
  logic mem_rsp_valid = 1'b0;
  logic cpu_clk_en, chan_clk_inhibit, busy, done;
  logic [11:0] uaddr;
  logic [2:0] seq_count;
  logic io_mode, sup_en_store, scan_on, supervisory;

  int checks = 0, errors = 0;
  logic stall = 1'b0;
  logic [31:0] mem [0:63];
  int cyc = 0, en_total = 0, done_total = 0, wn = 0, rn = 0;
  logic [AW-1:0] wlog_addr [0:63];
  logic [31:0]   wlog_data [0:63];
  int            wlog_en   [0:63];
  logic [AW-1:0] rlog_addr [0:63];

  diag_scan_seq i_diag_scan_seq (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (cpu_clk_en) en_total <= en_total + 1;
    if (done) done_total <= done_total + 1;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        wlog_addr[wn[5:0]] <= mem_req_addr;
        wlog_data[wn[5:0]] <= mem_req_wdata;
        wlog_en[wn[5:0]]   <= en_total;
        wn <= wn + 1;
      end else begin
        rlog_addr[rn[5:0]] <= mem_req_addr;
        rn <= rn + 1;
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[mem_req_addr[7:2]];
      end
    end
  end

  always @(negedge clk) mem_req_ready <= stall ? (cyc % 4 == 3) : 1'b1;

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: act=hung exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk_imm(logic [2:0] c, logic sen, logic ps, logic sup);
    return {1'b0, c, 1'b0, sen, ps, sup};
  endfunction

  function automatic logic [31:0] mk_word(logic io, logic [11:0] ua);
    logic [31:0] w = 32'h5A3C_7000;
    w[23] = io; w[11:0] = ua;
    return w;
  endfunction

  function automatic logic [31:0] mk_link(logic [2:0] c, logic sen, logic ps, logic sup,
                                          logic io, logic [11:0] ua);
    logic [31:0] w = 32'h0000_0000;
    w[31:29] = c; w[27] = sen; w[26] = ps; w[25] = sup; w[24] = io; w[12:1] = ua;
    w[0] = 1'b1; w[16] = 1'b1;
    return w;
  endfunction

  task automatic do_start(logic [31:0] w, logic [7:0] im, logic [AW-1:0] ia);
    @(negedge clk);
    start_word = w; start_imm = im; instr_addr = ia; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(string req);
    int n = 0;
    while (busy && n < 3000) begin @(negedge clk); n++; end
    @(negedge clk);
    check(req, {31'b0, busy}, 32'h0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 busy", {31'b0, busy}, 0);
    check("R1 done", {31'b0, done}, 0);
    check("R1 clk_en", {31'b0, cpu_clk_en}, 0);
    check("R1 req_valid", {31'b0, mem_req_valid}, 0);
    check("R1 fields", {15'b0, uaddr, seq_count, io_mode, sup_en_store, scan_on, supervisory}, 0);
  endtask

  task automatic t_single();
    int e0 = en_total, d0 = done_total, w0 = wn, r0 = rn;
    do_start(mk_word(1'b1, 12'h9D3), mk_imm(3'd5, 1'b1, 1'b0, 1'b1), 24'h40);
    check("R3 uaddr", {20'b0, uaddr}, 32'h9D3);
    check("R3 io_mode", {31'b0, io_mode}, 1);
    check("R4 count", {29'b0, seq_count}, 5);
    check("R4 flags", {29'b0, sup_en_store, scan_on, supervisory}, 3'b101);
    wait_idle("R7 busy");
    check("R5 clk_en cycles", en_total - e0, 5);
    check("R7 done pulses", done_total - d0, 1);
    check("R2 write count", wn - w0, 2);
    check("R2 addr0", {8'b0, wlog_addr[w0[5:0]]}, 32'h80);
    check("R2 data0", wlog_data[w0[5:0]], mk_word(1'b1, 12'h9D3));
    check("R2 addr1", {8'b0, wlog_addr[(w0+1)%64]}, 32'h84);
    check("R2 data1", wlog_data[(w0+1)%64], {mk_imm(3'd5, 1'b1, 1'b0, 1'b1), 24'h0});
    check("R2 writes before enable", wlog_en[(w0+1)%64] - e0, 0);
    check("R5 count ends zero", {29'b0, seq_count}, 0);
    check("R6 no read without scan", rn - r0, 0);
  endtask

  task automatic t_zero();
    int e0 = en_total, d0 = done_total;
    do_start(mk_word(1'b0, 12'h011), mk_imm(3'd0, 1'b0, 1'b0, 1'b1), 24'h40);
    wait_idle("R7 busy zero");
    check("R7 zero count no enable", en_total - e0, 0);
    check("R7 zero count done", done_total - d0, 1);
  endtask

  task automatic t_chain(string tag);
    int e0 = en_total, d0 = done_total, r0 = rn;
    mem[17] = mk_link(3'd3, 1'b0, 1'b1, 1'b1, 1'b1, 12'h3C5);
    mem[18] = mk_link(3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 12'hABC);
    do_start(mk_word(1'b0, 12'h100), mk_imm(3'd2, 1'b0, 1'b1, 1'b1), 24'h40);
    wait_idle({tag, " busy"});
    check({tag, " R5 total enables"}, en_total - e0, 6);
    check({tag, " R8 read count"}, rn - r0, 2);
    check({tag, " R8 first read"}, {8'b0, rlog_addr[r0[5:0]]}, 32'h44);
    check({tag, " R8 second read"}, {8'b0, rlog_addr[(r0+1)%64]}, 32'h48);
    check({tag, " R6 uaddr"}, {20'b0, uaddr}, 32'hABC);
    check({tag, " R6 flags"}, {28'b0, sup_en_store, scan_on, supervisory, io_mode}, 4'b1010);
    check({tag, " R7 done"}, done_total - d0, 1);
  endtask

  task automatic t_freerun();
    int e0, d0 = done_total;
    do_start(mk_word(1'b0, 12'h222), mk_imm(3'd3, 1'b0, 1'b1, 1'b0), 24'h40);
    repeat (3) @(negedge clk);
    e0 = en_total;
    repeat (20) @(negedge clk);
    check("R9 enable held", en_total - e0, 20);
    check("R9 count frozen", {29'b0, seq_count}, 3);
    check("R9 still busy", {31'b0, busy}, 1);
    check("R9 no done", done_total - d0, 0);
    do_start(mk_word(1'b1, 12'h777), mk_imm(3'd1, 1'b0, 1'b0, 1'b1), 24'h40);
    check("R9 restart accepted", {20'b0, uaddr}, 32'h777);
    wait_idle("R9 restart busy");
    check("R9 restart done", done_total - d0, 1);
  endtask

  task automatic t_ignore();
    int e0 = en_total, w0 = wn;
    do_start(mk_word(1'b0, 12'h5E5), mk_imm(3'd7, 1'b0, 1'b0, 1'b1), 24'h40);
    repeat (3) @(negedge clk);
    do_start(mk_word(1'b1, 12'h0F0), mk_imm(3'd2, 1'b1, 1'b1, 1'b1), 24'h40);
    check("R10 uaddr kept", {20'b0, uaddr}, 32'h5E5);
    wait_idle("R10 busy");
    check("R10 enables", en_total - e0, 7);
    check("R10 writes", wn - w0, 2);
    check("R10 io_mode kept", {31'b0, io_mode}, 0);
  endtask

  task automatic t_inhibit();
    @(negedge clk); if_diag_bit = 1'b1;
    @(negedge clk);
    check("R12 inhibit on", {31'b0, chan_clk_inhibit}, 1);
    if_diag_bit = 1'b0;
    @(negedge clk);
    check("R12 inhibit off", {31'b0, chan_clk_inhibit}, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_zero();
    t_chain("R6");
    stall = 1'b1;
    t_chain("R11");
    stall = 1'b0;
    t_freerun();
    t_ignore();
    t_inhibit();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule